// File: doc/BRIEF.md
# Clock-Master Synchronous Serial Receiver

This block receives serial words while driving the shift clock itself. A programmable divisor sets the clock rate. The data line is sampled on every falling clock edge, with the least significant bit first. Each word is 8 bits, or 9 bits when the ninth-bit option is on. A line-error input is captured alongside each word. Finished words move into a receive FIFO with two entries.

Receiving starts in one of two ways. A one-shot enable receives a single word and then clears itself. A level-sensitive continuous enable keeps receiving until it is dropped, and it takes precedence when both enables are set. A ready flag, gated by an interrupt enable, tells the host that data is waiting. Status bits show the entry at the head of the FIFO until the host pops it with a read strobe. An overrun flag freezes transfers into the FIFO until the host clears it.

Top module: `sync_rx_master`

## Requirements
- R1: While receiving, `sclk_o` spends exactly `div_i + 1` system clock cycles in each high phase and each low phase, starting low. Whenever the block is not receiving, `sclk_o` is low from the next cycle on.
- R2: `sdata_i` is sampled in the cycle in which `sclk_o` falls. Bit 0 comes from the first falling edge after receive starts. The data byte is assembled least significant bit first, and the ninth bit (when `nine_en_i` is 1) is sampled last.
- R3: A pulse on `single_set_i` sets `single_en_o`. With `cont_en_i` low, exactly one word is received, and `single_en_o` clears on that word's last falling edge.
- R4: With `cont_en_i` high, words are received back to back. If `single_en_o` is also set, continuous mode wins: `single_en_o` stays set and receiving carries on past the first word.
- R5: A finished word enters the FIFO when fewer than two entries are held. Two words can be held while a third is still shifting in.
- R6: If the FIFO holds two entries when a word finishes, `overrun_o` goes to 1 and that word is dropped.
- R7: While `overrun_o` is 1, no word enters the FIFO. The flag clears only on a high-to-low change of `cont_en_i` or while `port_en_i` is 0.
- R8: `rx_ready_o` is 1 whenever the FIFO is not empty, and it drops only after reads have emptied it. `irq_o` equals `rx_ready_o` when `int_en_i` is 1 and is 0 otherwise.
- R9: `stat_bit9_o` and `stat_err_o` show the ninth bit and captured line error of the head entry, or 0 when the FIFO is empty. In 8-bit mode the ninth bit reads 0. A pop moves both to the next entry.
- R10: A pop when the FIFO is empty leaves `data_o` and the FIFO unchanged. `data_o` shows the most recently popped byte, and 0 after reset.
- R11: Dropping both enables, or dropping `port_en_i`, resets the clock and the bit counter. The next receive starts again at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Serial port enable |
| single_set_i | input | 1 | Pulse that arms one-word receive |
| cont_en_i | input | 1 | Continuous receive enable (level) |
| nine_en_i | input | 1 | Selects 9-bit words |
| int_en_i | input | 1 | Interrupt enable for the ready flag |
| div_i | input | 8 | Half-period divisor for the shift clock |
| sdata_i | input | 1 | Serial data line |
| line_err_i | input | 1 | Error status captured on each word's last bit |
| pop_i | input | 1 | Data read strobe |
| sclk_o | output | 1 | Generated shift clock |
| single_en_o | output | 1 | One-shot enable state |
| rx_ready_o | output | 1 | FIFO holds data |
| irq_o | output | 1 | Gated ready interrupt |
| overrun_o | output | 1 | Overrun flag |
| stat_bit9_o | output | 1 | Ninth bit of the head entry |
| stat_err_o | output | 1 | Error status of the head entry |
| data_o | output | 8 | Last popped data byte |

## Verification
- **Bit counter out of step.** The bad count shows up on the very next word that is popped, as shifted data or a wrong ninth bit. Restarts in the middle of a word are aimed at exactly this fault.
- **FIFO occupancy wrong.** An occupancy counter that is off by one makes `overrun_o` rise one word early or one word late. It also makes `rx_ready_o` fall after the wrong pop, so it shows within one word time.
- **Stale overrun flag.** A flag that fails to clear shows at the ports as `rx_ready_o` staying low after the next complete word.
- **One-shot enable stuck high.** A one-shot state that never clears shows as `sclk_o` still toggling after the first word.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic              err;
    logic              bit9;
    logic [DATA_W-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/sync_rx_baud.sv
module sync_rx_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             tick;

  assign tick   = (cnt_q >= div_i);
  assign fall_o = run_i & tick & sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sync_rx_shift.sv
module sync_rx_shift
  import sync_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  logic     fall_i,
  input  logic     nine_i,
  input  logic     sdata_i,
  input  logic     err_i,
  output logic     last_o,
  output logic     done_o,
  output rx_word_t word_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [DATA_W:0] sh_q;
  logic [CNT_W-1:0] bcnt_q;
  logic [CNT_W-1:0] last_idx;
  logic             err_q;
  logic             done_q;

  assign last_idx = nine_i ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign last_o   = fall_i & (bcnt_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcnt_q <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (!run_i) begin
      bcnt_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (fall_i) begin
        // clearing at bit 0 keeps the ninth position 0 in 8-bit mode
        if (bcnt_q == '0) sh_q <= {{DATA_W{1'b0}}, sdata_i};
        else              sh_q[bcnt_q] <= sdata_i;
        if (last_o) begin
          bcnt_q <= '0;
          err_q  <= err_i;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o      = done_q;
  assign word_o.err  = err_q;
  assign word_o.bit9 = sh_q[DATA_W];
  assign word_o.data = sh_q[DATA_W-1:0];
endmodule

// File: rtl/sync_rx_fifo.sv
module sync_rx_fifo
  import sync_rx_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  rx_word_t                   din_i,
  input  logic                       pop_i,
  output rx_word_t                   head_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o,
  output logic                       full_o,
  output logic                       empty_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rx_word_t         mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign head_o  = mem_q[rptr_q];
  assign cnt_o   = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[i] <= '0;
      else if (do_push && wptr_q == PTR_W'(i))   mem_q[i] <= din_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic              single_set_i,
  input  logic              cont_en_i,
  input  logic              nine_en_i,
  input  logic              int_en_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              sdata_i,
  input  logic              line_err_i,
  input  logic              pop_i,
  output logic              sclk_o,
  output logic              single_en_o,
  output logic              rx_ready_o,
  output logic              irq_o,
  output logic              overrun_o,
  output logic              stat_bit9_o,
  output logic              stat_err_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic             single_q, cont_q, ovr_q;
  logic             run, fall, word_last, word_done, push;
  rx_word_t         word, head, rd_q;
  logic [CNT_W-1:0] fifo_cnt;
  logic             fifo_full, fifo_empty;

  assign run = port_en_i & (cont_en_i | single_q);

  sync_rx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .sclk_o (sclk_o),
    .fall_o (fall)
  );

  sync_rx_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .fall_i  (fall),
    .nine_i  (nine_en_i),
    .sdata_i (sdata_i),
    .err_i   (line_err_i),
    .last_o  (word_last),
    .done_o  (word_done),
    .word_o  (word)
  );

  assign push = word_done & ~ovr_q & ~fifo_full;

  sync_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   (word),
    .pop_i   (pop_i),
    .head_o  (head),
    .cnt_o   (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_q <= 1'b0;
      cont_q   <= 1'b0;
      ovr_q    <= 1'b0;
      rd_q     <= '0;
    end else begin
      cont_q <= cont_en_i;
      // one-shot: set wins over self-clear; continuous mode holds it
      if (!port_en_i)                   single_q <= 1'b0;
      else if (single_set_i)            single_q <= 1'b1;
      else if (word_last && !cont_en_i) single_q <= 1'b0;

      if (!port_en_i || (cont_q && !cont_en_i)) ovr_q <= 1'b0;
      else if (word_done && fifo_full)         ovr_q <= 1'b1;

      if (pop_i && !fifo_empty) rd_q <= head;
    end
  end

  assign single_en_o = single_q;
  assign rx_ready_o  = ~fifo_empty;
  assign irq_o       = ~fifo_empty & int_en_i;
  assign overrun_o   = ovr_q;
  assign stat_bit9_o = ~fifo_empty & head.bit9;
  assign stat_err_o  = ~fifo_empty & head.err;
  assign data_o      = rd_q.data;
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk #(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             port_en_i,
  input logic             cont_en_i,
  input logic             pop_i,
  input logic             sclk_o,
  input logic             single_en_o,
  input logic             rx_ready_o,
  input logic             overrun_o,
  input logic [7:0]       data_o,
  input logic             word_last,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             fifo_full
);
  a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_en_i && (cont_en_i || single_en_o)) |=> !sclk_o);

  a_r3_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(single_en_o) |-> ($past(word_last) || !$past(port_en_i)));

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(DEPTH));

  a_r6_overrun_on_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(fifo_full));

  a_r7_no_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(overrun_o) |-> fifo_cnt <= $past(fifo_cnt));

  a_r8_ready_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_o && !pop_i |=> rx_ready_o);

  a_r10_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && !rx_ready_o |=> $stable(data_o));
endmodule

bind sync_rx_master sync_rx_master_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sync_rx_master_tb.sv
module sync_rx_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0, single_set = 1'b0, cont_en = 1'b0;
  logic       nine_en = 1'b0, int_en = 1'b0, line_err = 1'b0, pop = 1'b0;
  logic [7:0] div = 8'd1;
  logic       sdata = 1'b0;
  logic       sclk, single_en, rx_ready, irq, overrun, st9, sterr;
  logic [7:0] data;

  int  checks = 0, errors = 0;
  logic stream [64];
  int  sp = 0;
  logic sclk_d = 1'b0;
  logic restart = 1'b0;

  // {nine, err, word[8:0]}
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 1'b0, 9'h0A5}, {1'b0, 1'b1, 9'h03C}, {1'b1, 1'b0, 9'h1F0},
    {1'b1, 1'b1, 9'h00F}, {1'b1, 1'b0, 9'h081}, {1'b0, 1'b0, 9'h1FF}
  };

  always #5 clk = ~clk;

  sync_rx_master u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(port_en), .single_set_i(single_set),
    .cont_en_i(cont_en), .nine_en_i(nine_en), .int_en_i(int_en), .div_i(div),
    .sdata_i(sdata), .line_err_i(line_err), .pop_i(pop), .sclk_o(sclk),
    .single_en_o(single_en), .rx_ready_o(rx_ready), .irq_o(irq),
    .overrun_o(overrun), .stat_bit9_o(st9), .stat_err_o(sterr), .data_o(data)
  );

  // serial source: next bit on every shift-clock rise
  always @(negedge clk) begin
    sclk_d <= sclk;
    if (restart) sp <= 0;
    else if (sclk && !sclk_d) begin
      sdata <= (sp < 64) ? stream[sp] : 1'b0;
      sp    <= sp + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic clear_stream();
    for (int i = 0; i < 64; i++) stream[i] = 1'b0;
  endtask

  task automatic put_word(input int idx, input logic [8:0] w, input bit nine);
    int nb = nine ? 9 : 8;
    for (int i = 0; i < nb; i++) stream[idx*nb+i] = w[i];
  endtask

  task automatic do_restart();
    restart = 1'b1;
    step();
    restart = 1'b0;
  endtask

  task automatic pulse_single();
    single_set = 1'b1;
    step();
    single_set = 1'b0;
  endtask

  task automatic pop_once();
    pop = 1'b1;
    step();
    pop = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_sig(input string req, input bit want_ovr);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(want_ovr ? overrun : rx_ready) && n < 2000);
    if (n >= 2000) chk(req, 0, 1);
  endtask

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_stream();
    step(3);
    @(negedge clk);
    chk("R1 reset sclk", sclk, 0);
    chk("R8 reset ready", rx_ready, 0);
    chk("R8 reset irq", irq, 0);
    chk("R7 reset overrun", overrun, 0);
    chk("R10 reset data", data, 0);
    chk("R3 reset single", single_en, 0);
    rst_n = 1'b1;
    step(2);
    port_en = 1'b1;

    // R1: high phase length = div+1
    begin
      int hi = 0;
      div = 8'd3;
      do_restart();
      cont_en = 1'b1;
      do @(negedge clk); while (!sclk);
      while (sclk) begin
        hi++;
        @(negedge clk);
      end
      chk("R1 high phase", hi, 4);
      hi = 0;
      while (!sclk) begin
        hi++;
        @(negedge clk);
      end
      chk("R1 low phase", hi, 4);
      step();
      cont_en = 1'b0;
      step();
      @(negedge clk);
      chk("R1 idle low", sclk, 0);
      chk("R11 no partial word", rx_ready, 0);
    end

    // table walk: one-shot words, R2 R3 R9
    div = 8'd1;
    int_en = 1'b1;
    for (int v = 0; v < 6; v++) begin
      logic [10:0] e = VEC[v];
      clear_stream();
      put_word(0, e[8:0], e[10]);
      nine_en = e[10];
      line_err = e[9];
      do_restart();
      pulse_single();
      wait_sig("R3 word arrives", 0);
      chk("R3 single cleared", single_en, 0);
      chk("R8 irq with enable", irq, 1);
      chk("R9 ninth bit", st9, e[10] & e[8]);
      chk("R9 error bit", sterr, e[9]);
      pop_once();
      chk("R2 data byte", data, e[7:0]);
      chk("R8 ready after drain", rx_ready, 0);
    end
    line_err = 1'b0;
    nine_en = 1'b0;
    step(40);
    chk("R3 one word only", rx_ready, 0);
    chk("R3 clock stopped", sclk, 0);

    // R8: interrupt gating
    int_en = 1'b0;
    clear_stream();
    put_word(0, 9'h066, 0);
    do_restart();
    pulse_single();
    wait_sig("R8 gated word", 0);
    chk("R8 irq masked", irq, 0);
    pop_once();
    chk("R2 gated data", data, 8'h66);

    // R5 R6 R7 R10: continuous fill and overrun
    clear_stream();
    put_word(0, 9'h011, 0);
    put_word(1, 9'h022, 0);
    put_word(2, 9'h033, 0);
    put_word(3, 9'h044, 0);
    put_word(4, 9'h055, 0);
    do_restart();
    cont_en = 1'b1;
    wait_sig("R6 overrun rises", 1);
    chk("R5 ready while full", rx_ready, 1);
    pop_once();
    chk("R5 first entry", data, 8'h11);
    chk("R8 ready after one pop", rx_ready, 1);
    pop_once();
    chk("R6 second entry kept", data, 8'h22);
    chk("R8 ready cleared", rx_ready, 0);
    step(40);
    @(negedge clk);
    chk("R7 transfers blocked", rx_ready, 0);
    chk("R7 flag held", overrun, 1);
    pop_once();
    chk("R10 empty pop data", data, 8'h22);
    chk("R10 empty pop ready", rx_ready, 0);
    cont_en = 1'b0;
    step();
    @(negedge clk);
    chk("R7 cleared by cont fall", overrun, 0);
    chk("R11 clock reset", sclk, 0);

    // R4: continuous wins over one-shot
    clear_stream();
    put_word(0, 9'h0C1, 0);
    put_word(1, 9'h0D2, 0);
    do_restart();
    cont_en = 1'b1;
    pulse_single();
    wait_sig("R4 first word", 0);
    pop_once();
    chk("R4 first data", data, 8'hC1);
    chk("R4 single held", single_en, 1);
    wait_sig("R4 second word", 0);
    pop_once();
    chk("R4 second data", data, 8'hD2);
    cont_en = 1'b0;
    port_en = 1'b0;
    step();
    @(negedge clk);
    chk("R11 port off single", single_en, 0);
    chk("R11 port off clock", sclk, 0);
    if (rx_ready) pop_once();
    port_en = 1'b1;

    // R11: abort mid-word, restart from bit 0
    clear_stream();
    put_word(0, 9'h0FF, 0);
    do_restart();
    cont_en = 1'b1;
    step(12);
    cont_en = 1'b0;
    step();
    @(negedge clk);
    chk("R11 abort clock", sclk, 0);
    clear_stream();
    put_word(0, 9'h03C, 0);
    do_restart();
    pulse_single();
    wait_sig("R11 restart word", 0);
    pop_once();
    chk("R11 clean restart data", data, 8'h3C);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule